// File: doc/BRIEF.md
# Sliding-Window Local-Maximum Cluster Finder

This block searches a frame of calorimeter trigger-tower transverse energies for energy clusters. The frame is a grid of `NETA` rows in eta by `NPHI` columns in phi (40 by 32 by default). One eta row of 8-bit tower energies arrives per strobe, with a start-of-frame flag on row 0. For every tower position the block forms a 2x2 core sum. A core becomes a cluster candidate when its sum is a local maximum among the 24 overlapping cores within two positions of it. Each such decision looks at a 6x6 tower neighbourhood.

Tie-breaking is asymmetric, so a flat plateau yields at most one candidate. A candidate is reported only when its core sum reaches a programmable threshold. Records come out one per clock in raster order (eta row, then phi), each with its eta index, phi index and 10-bit sum. A one-cycle end-of-frame pulse follows the last record.

Phi is cyclic. Eta positions beyond either edge of the grid hold zero energy. The block keeps a short history of core-sum rows instead of a whole frame. It appends three zero rows by itself after the last input row, so that the last core rows can be judged.

Top module: `cf_cluster_finder`

## Requirements
- R1: While and directly after reset, `out_valid` and `out_eof` are low and no record is emitted.
- R2: A record carries `out_eta` = eta index e of the core's lower tower row (0..NETA-1) and `out_phi` = phi index p (0..NPHI-1). It carries `out_sum` = T(e,p)+T(e+1,p)+T(e,p+1)+T(e+1,p+1), where tower T(e,p) is bits [p*8+7:p*8] of the row with eta index e.
- R3: Core (e,p) is a local maximum when its sum is strictly greater than every core (e+de,p+dp) with de,dp in -2..2 that is later in raster order (de>0, or de=0 and dp>0). It must also be greater than or equal to every such core that is earlier.
- R4: A local maximum is reported only when its sum is greater than or equal to `in_thr`.
- R5: Phi indices wrap modulo NPHI. Towers at eta indices below 0 or above NETA-1 count as zero.
- R6: Records come out in raster order. The record for core (c,p) is valid in the cycle after the clock edge that is 1+p edges after the push of row c+3. A push is either the input row c+3 or an internal zero row.
- R7: The internal zero rows NETA..NETA+2 are pushed NPHI+1 cycles apart after the last input row. A single-cycle `out_eof` pulse is valid in the cycle after the edge NPHI+1 edges after the last zero-row push.
- R8: A row strobe without `in_sof` outside the rows 1..NETA-1 of a frame is ignored and produces no record.
- R9: Row strobes must be at least NPHI+1 cycles apart, and the next frame's start must follow `out_eof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_row_valid | input | 1 | Row strobe |
| in_sof | input | 1 | Marks row 0 of a frame |
| in_row | input | NPHI*8 | Tower energies of one eta row, phi p in bits [p*8+7:p*8] |
| in_thr | input | 10 | Minimum core sum, held stable during a frame |
| out_valid | output | 1 | Record valid |
| out_eta | output | 6 | Eta index of the core |
| out_phi | output | 5 | Phi index of the core |
| out_sum | output | 10 | Core sum |
| out_eof | output | 1 | One-cycle end-of-frame pulse |

## Verification
Every result has a fixed cycle position relative to the capture edge of frame row 0. Rows are pushed every NPHI+1 cycles, external and internal alike. The record for core (c,p) is due after edge (c+3)(NPHI+1)+1+p, and the end-of-frame pulse is due after edge (NETA+2)(NPHI+1)+NPHI+1. The bench drives rows at exactly that spacing. In every cycle it works out from its own copy of the grid whether a record or the pulse is due, and compares valid, fields and pulse 2 ns after each rising edge. The frames cover an isolated tower, an adjacent tie, phi wrap, the eta edges, an exact threshold match, a flat plateau and random sparse grids.

// File: rtl/cf_pkg.sv
package cf_pkg;
  // neighbourhood reach in core positions on each side of the centre
  localparam int CF_REACH = 2;
  localparam int CF_DEPTH = 2 * CF_REACH + 1;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_FILL,
    SQ_FLUSH,
    SQ_DRAIN
  } seq_state_e;
endpackage

// File: rtl/cf_core_sum.sv
// Forms one row of 2x2 core sums from two adjacent tower rows, phi cyclic.
module cf_core_sum #(
  parameter int NPHI  = 32,
  parameter int ET_W  = 8,
  parameter int SUM_W = ET_W + 2
) (
  input  logic [NPHI*ET_W-1:0]         row_lo,
  input  logic [NPHI*ET_W-1:0]         row_hi,
  output logic [NPHI-1:0][SUM_W-1:0]   sums
);
  for (genvar p = 0; p < NPHI; p++) begin : g_col
    localparam int PN = (p + 1) % NPHI;
    assign sums[p] = SUM_W'(row_lo[p*ET_W +: ET_W])  + SUM_W'(row_lo[PN*ET_W +: ET_W])
                   + SUM_W'(row_hi[p*ET_W +: ET_W])  + SUM_W'(row_hi[PN*ET_W +: ET_W]);
  end
endmodule

// File: rtl/cf_peak_eval.sv
// Decides whether the core at phi position `phi` of the centre row is a
// local maximum. rows[0] is the newest (latest eta) row, rows[REACH] the centre.
module cf_peak_eval #(
  parameter int NPHI  = 32,
  parameter int SUM_W = 10,
  parameter int PHI_W = 5,
  parameter int REACH = 2,
  localparam int DEPTH = 2 * REACH + 1
) (
  input  logic [DEPTH-1:0][NPHI-1:0][SUM_W-1:0] rows,
  input  logic [PHI_W-1:0]                      phi,
  input  logic [SUM_W-1:0]                      thr,
  output logic                                  hit,
  output logic [SUM_W-1:0]                      centre
);
  logic [DEPTH-1:0][DEPTH-1:0] pass;

  assign centre = rows[REACH][phi];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_row
    for (genvar gj = 0; gj < DEPTH; gj++) begin : g_col
      localparam int DP = gj - REACH;
      localparam bit LATER = (gi < REACH) || (gi == REACH && DP > 0);
      if (gi == REACH && gj == REACH) begin : g_self
        assign pass[gi][gj] = 1'b1;
      end else begin : g_nb
        logic [PHI_W-1:0] nidx;
        always_comb begin
          int t;
          t = int'(phi) + DP;
          if (t < 0) t = t + NPHI;
          else if (t >= NPHI) t = t - NPHI;
          nidx = PHI_W'(t);
        end
        if (LATER) begin : g_strict
          assign pass[gi][gj] = centre > rows[gi][nidx];
        end else begin : g_loose
          assign pass[gi][gj] = centre >= rows[gi][nidx];
        end
      end
    end
  end

  assign hit = (&pass) && (centre >= thr);
endmodule

// File: rtl/cf_cluster_finder.sv
module cf_cluster_finder
  import cf_pkg::*;
#(
  parameter int  NETA  = 40,
  parameter int  NPHI  = 32,
  parameter int  ET_W  = 8,
  localparam int SUM_W = ET_W + 2,
  localparam int ETA_W = $clog2(NETA),
  localparam int PHI_W = $clog2(NPHI)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_row_valid,
  input  logic                   in_sof,
  input  logic [NPHI*ET_W-1:0]   in_row,
  input  logic [SUM_W-1:0]       in_thr,
  output logic                   out_valid,
  output logic [ETA_W-1:0]       out_eta,
  output logic [PHI_W-1:0]       out_phi,
  output logic [SUM_W-1:0]       out_sum,
  output logic                   out_eof
);
  localparam int TOTAL = NETA + CF_REACH + 1;          // pushes per frame
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] CNT_LAST_EXT = CNT_W'(NETA);
  localparam logic [CNT_W-1:0] CNT_TOTAL    = CNT_W'(TOTAL);
  localparam logic [CNT_W-1:0] CNT_FIRST_SC = CNT_W'(CF_REACH + 2);
  localparam logic [PHI_W-1:0] PHI_LAST     = PHI_W'(NPHI - 1);

  // ---------------- state ----------------
  seq_state_e                                st_q, st_d;
  logic [CNT_W-1:0]                          pcnt_q, pcnt_d;
  logic [NPHI*ET_W-1:0]                      prev_q, prev_d;
  logic [CF_DEPTH-1:0][NPHI-1:0][SUM_W-1:0]  pipe_q, pipe_d;
  logic                                      busy_q, busy_d;
  logic [PHI_W-1:0]                          ph_q, ph_d;
  logic [ETA_W-1:0]                          ceta_q, ceta_d;
  logic                                      oval_q, oval_d, oeof_q, oeof_d;
  logic [ETA_W-1:0]                          oeta_q;
  logic [PHI_W-1:0]                          ophi_q;
  logic [SUM_W-1:0]                          osum_q;

  // ---------------- push control ----------------
  logic                   take_ext, take_flush, push, sof_push;
  logic [NPHI*ET_W-1:0]   new_row, lo_row;
  logic [NPHI-1:0][SUM_W-1:0] new_sums;
  logic [CNT_W-1:0]       pcnt_next;
  logic                   pk_hit;
  logic [SUM_W-1:0]       pk_sum;

  assign take_ext   = in_row_valid && (in_sof || st_q == SQ_FILL);
  assign take_flush = (st_q == SQ_FLUSH) && !busy_q && !take_ext;
  assign push       = take_ext || take_flush;
  assign sof_push   = take_ext && in_sof;
  assign new_row    = take_ext ? in_row : '0;
  assign lo_row     = sof_push ? '0 : prev_q;
  assign pcnt_next  = sof_push ? CNT_W'(1) : pcnt_q + CNT_W'(1);

  cf_core_sum #(.NPHI(NPHI), .ET_W(ET_W), .SUM_W(SUM_W)) u_core_sum (
    .row_lo (lo_row),
    .row_hi (new_row),
    .sums   (new_sums)
  );

  cf_peak_eval #(.NPHI(NPHI), .SUM_W(SUM_W), .PHI_W(PHI_W), .REACH(CF_REACH)) u_peak (
    .rows   (pipe_q),
    .phi    (ph_q),
    .thr    (in_thr),
    .hit    (pk_hit),
    .centre (pk_sum)
  );

  // ---------------- next state ----------------
  always_comb begin
    st_d   = st_q;
    pcnt_d = pcnt_q;
    prev_d = prev_q;
    pipe_d = pipe_q;
    busy_d = busy_q;
    ph_d   = ph_q;
    ceta_d = ceta_q;
    oeof_d = 1'b0;
    oval_d = busy_q && pk_hit;

    // scan advance, one phi position per cycle
    if (busy_q) begin
      if (ph_q == PHI_LAST) busy_d = 1'b0;
      else                  ph_d   = ph_q + PHI_W'(1);
    end

    // frame completion
    if (st_q == SQ_DRAIN && !busy_q) begin
      oeof_d = 1'b1;
      st_d   = SQ_IDLE;
    end

    if (push) begin
      prev_d    = new_row;
      pipe_d[0] = new_sums;
      for (int i = 1; i < CF_DEPTH; i++) pipe_d[i] = sof_push ? '0 : pipe_q[i-1];
      pcnt_d = pcnt_next;
      if (take_ext)                              st_d = (pcnt_next == CNT_LAST_EXT) ? SQ_FLUSH : SQ_FILL;
      else if (pcnt_next == CNT_TOTAL)           st_d = SQ_DRAIN;
      if (pcnt_next >= CNT_FIRST_SC) begin
        busy_d = 1'b1;
        ph_d   = '0;
        ceta_d = ETA_W'(pcnt_next - CNT_FIRST_SC);
      end
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      pcnt_q <= '0;
      prev_q <= '0;
      pipe_q <= '0;
      busy_q <= 1'b0;
      ph_q   <= '0;
      ceta_q <= '0;
      oval_q <= 1'b0;
      oeof_q <= 1'b0;
      oeta_q <= '0;
      ophi_q <= '0;
      osum_q <= '0;
    end else begin
      st_q   <= st_d;
      busy_q <= busy_d;
      ph_q   <= ph_d;
      oval_q <= oval_d;
      oeof_q <= oeof_d;
      if (push) begin
        pcnt_q <= pcnt_d;
        prev_q <= prev_d;
        pipe_q <= pipe_d;
        ceta_q <= ceta_d;
      end
      if (oval_d) begin
        oeta_q <= ceta_q;
        ophi_q <= ph_q;
        osum_q <= pk_sum;
      end
    end
  end

  assign out_valid = oval_q;
  assign out_eta   = oeta_q;
  assign out_phi   = ophi_q;
  assign out_sum   = osum_q;
  assign out_eof   = oeof_q;

  // ---------------- assertions ----------------
  assert_row_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_row_valid |-> !busy_q);

  assert_sum_reaches_thr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_sum >= $past(in_thr));

  assert_raster_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ph_q != PHI_LAST && !in_row_valid) |=> (busy_q && ph_q == $past(ph_q) + PHI_W'(1)));

  assert_eof_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> (!out_valid && !busy_q));

  assert_eof_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |=> !out_eof);

  assert_eta_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_eta) < NETA));
endmodule

// File: tb/test_cf_cluster_finder.sv
module test_cf_cluster_finder;
  localparam int NETA = 40;
  localparam int NPHI = 32;
  localparam int ET_W = 8;
  localparam int SUM_W = ET_W + 2;
  localparam int G = NPHI + 1;   // row spacing used throughout (R9)

  logic                 clk;
  logic                 rst_n;
  logic                 in_row_valid, in_sof;
  logic [NPHI*ET_W-1:0] in_row;
  logic [SUM_W-1:0]     in_thr;
  logic                 out_valid, out_eof;
  logic [5:0]           out_eta;
  logic [4:0]           out_phi;
  logic [SUM_W-1:0]     out_sum;

  cf_cluster_finder #(.NETA(NETA), .NPHI(NPHI), .ET_W(ET_W)) i_cf_cluster_finder (
    .clk, .rst_n, .in_row_valid, .in_sof, .in_row, .in_thr,
    .out_valid, .out_eta, .out_phi, .out_sum, .out_eof
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int  grid [NETA][NPHI];
  int  thr_v;
  bit  frame_on;
  int  t0;
  int  ncyc;
  int  nvec, nbad;

  // ---------- behavioural model ----------
  function automatic int tw(int e, int p);
    if (e < 0 || e >= NETA) return 0;
    return grid[e][((p % NPHI) + NPHI) % NPHI];
  endfunction

  function automatic int cs(int e, int p);
    return tw(e, p) + tw(e+1, p) + tw(e, p+1) + tw(e+1, p+1);
  endfunction

  function automatic bit pk(int c, int p);
    int s;
    s = cs(c, p);
    if (s < thr_v) return 0;
    for (int de = -2; de <= 2; de++)
      for (int dp = -2; dp <= 2; dp++) begin
        int n;
        bit later;
        if (de == 0 && dp == 0) continue;
        n = cs(c+de, p+dp);
        later = (de > 0) || (de == 0 && dp > 0);
        if (later ? !(s > n) : !(s >= n)) return 0;
      end
    return 1;
  endfunction

  // ---------- per-clock comparison ----------
  always @(posedge clk) begin
    bit ev, eeof;
    int ee, ep, es;
    string tag;
    ncyc++;
    #2;
    ev = 0; eeof = 0; ee = 0; ep = 0; es = 0;
    if (rst_n && frame_on) begin
      int off;
      off = ncyc - t0;
      if (off > 0) begin
        int j, p;
        j = (off - 1) / G;
        p = (off - 1) % G;
        if (p < NPHI && j >= 3 && j <= NETA + 2 && pk(j-3, p)) begin
          ev = 1; ee = j - 3; ep = p; es = cs(j-3, p);
        end
      end
      if (off == (NETA + 2) * G + NPHI + 1) eeof = 1;
    end
    tag = !rst_n ? "R1" : (frame_on ? "R3 R4 R5 R6" : "R8");
    nvec++;
    if (out_valid !== ev) begin
      nbad++;
      $display("FAIL %s valid cyc=%0d act=%0b exp=%0b (exp rec %0d,%0d)", tag, ncyc, out_valid, ev, ee, ep);
    end else if (ev && (int'(out_eta) != ee || int'(out_phi) != ep || int'(out_sum) != es)) begin
      nbad++;
      $display("FAIL R2 record act=(%0d,%0d,%0d) exp=(%0d,%0d,%0d)", out_eta, out_phi, out_sum, ee, ep, es);
    end
    if (out_eof !== eeof) begin
      nbad++;
      $display("FAIL %s eof cyc=%0d act=%0b exp=%0b", rst_n ? "R7" : "R1", ncyc, out_eof, eeof);
    end
  end

  // ---------- stimulus ----------
  task automatic clear_grid();
    for (int e = 0; e < NETA; e++)
      for (int p = 0; p < NPHI; p++) grid[e][p] = 0;
  endtask

  task automatic run_frame(int thr);
    thr_v = thr;
    for (int r = 0; r < NETA; r++) begin
      @(negedge clk);
      if (r == 0) begin
        in_thr = SUM_W'(thr);
        t0 = ncyc + 1;
        frame_on = 1;
      end
      in_row_valid = 1'b1;
      in_sof = (r == 0);
      for (int p = 0; p < NPHI; p++) in_row[p*ET_W +: ET_W] = ET_W'(grid[r][p]);
      @(negedge clk);
      in_row_valid = 1'b0;
      in_sof = 1'b0;
      repeat (G - 2) @(negedge clk);
    end
    repeat (3 * G + NPHI + 6) @(negedge clk);
    frame_on = 0;
  endtask

  task automatic stray_row();  // R8: no sof, outside a frame
    @(negedge clk);
    in_row_valid = 1'b1;
    in_sof = 1'b0;
    for (int p = 0; p < NPHI; p++) in_row[p*ET_W +: ET_W] = 8'd200;
    @(negedge clk);
    in_row_valid = 1'b0;
    repeat (G + NPHI + 4) @(negedge clk);
  endtask

  bit done;

  initial begin
    nvec = 0; nbad = 0; ncyc = 0; frame_on = 0; t0 = 0; thr_v = 0; done = 0;
    rst_n = 1'b0;
    in_row_valid = 1'b0; in_sof = 1'b0; in_row = '0; in_thr = '0;
    clear_grid();
    repeat (5) @(negedge clk);   // R1 checked by the monitor during reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    stray_row();                 // R8 before any frame

    // R2 R3: isolated tower and an adjacent equal pair
    clear_grid();
    grid[10][5] = 50;
    grid[15][10] = 80; grid[15][11] = 80;
    run_frame(20);

    // R5: phi wrap and both eta edges
    clear_grid();
    grid[0][31] = 90; grid[0][0] = 40;
    grid[39][0] = 70;
    grid[20][31] = 30; grid[21][0] = 30;
    run_frame(30);

    stray_row();                 // R8 after a frame

    // R4: threshold exactly met, then one above
    clear_grid();
    grid[20][12] = 60;
    run_frame(60);
    run_frame(61);

    // R3: flat plateau gives no candidate
    for (int e = 0; e < NETA; e++)
      for (int p = 0; p < NPHI; p++) grid[e][p] = 10;
    run_frame(0);

    // R2 R3 R4 R6: random sparse grids
    for (int f = 0; f < 2; f++) begin
      for (int e = 0; e < NETA; e++)
        for (int p = 0; p < NPHI; p++)
          grid[e][p] = ($urandom_range(0, 9) < 2) ? int'($urandom_range(1, 255)) : 0;
      run_frame(f == 0 ? 100 : 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      nbad++;
      $display("FAIL R6 watchdog expired act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule